// File: doc/BRIEF.md
# Pin-Change Interrupt Controller

This block watches several groups of general-purpose input pins and turns a level change on any selected pin into a pending flag for that group. Each group has a per-pin select mask. A shared enable register holds one bit per group, and a shared pending register holds one flag per group. An enabled pending flag becomes an interrupt request toward the CPU core. When several groups are requesting at once, the request carries the number of the most urgent group.

The core takes a vector by pulsing an acknowledge while the request is high. At that moment the controller clears the pending flag of the group it just handed over. Because the flag is cleared when the vector is taken, a pin change that arrives while the handler runs sets the flag again, and a second interrupt follows the first. The return-from-interrupt pulse says nothing about which group finished, so it clears nothing. After a return, the request stays blocked until the core has retired one more instruction.

Software reaches the masks, the enables and the flags through a small synchronous register port. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `pin_change_irq`

## Requirements
- R1: Every pin passes through a two-flop synchroniser before edge detection. A change is found by comparing the synchronised sample with the one from the previous cycle. A pin that changes level before clock edge n makes its group's flag readable after edge n+2 and not before.
- R2: A change on a pin whose mask bit is 0 sets no flag. The mask of group g is at address g, with bit p selecting pin p of that group.
- R3: A flag is set by a selected change whether or not it is already set. It raises irqReq only when the group's enable bit (address GROUPS, bit g) is 1. A set flag with enable 0 leaves irqReq low.
- R4: Writing the pending register (address GROUPS+1, bit g for group g) clears each flag whose data bit is 1 and leaves flags with a 0 data bit unchanged.
- R5: If a hardware set and a software clear hit the same flag at the same edge, the flag ends up set.
- R6: When irqAck is high while irqReq is high, the flag of the group shown on irqId is cleared at that edge. All other flags are left alone.
- R7: A selected change that arrives while a handler is in service sets the flag again, and that flag produces a new request after the return gap.
- R8: After an accepted acknowledge, irqReq stays low until an rtiDone pulse. After that pulse it stays low until an instrRetire pulse arrives in a later cycle. A retire pulse in the same cycle as rtiDone does not count.
- R9: irqId gives the lowest-numbered group whose flag and enable are both set. irqReq is high exactly when such a group exists and no service or gap is in progress.
- R10: rtiDone clears no flag.
- R11: After reset, all masks, enables and flags read as zero and irqReq is low. Addresses outside the map read as zero.
- R12: irqAck while irqReq is low is ignored and does not start a service period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinsIn | input | GROUPS*PINS | Monitored pins; group g uses bits g*PINS and up |
| regAddr | input | ADDR_W | Register address |
| regWe | input | 1 | Write strobe |
| regWdata | input | PINS | Write data |
| regRdata | output | PINS | Read data for regAddr |
| irqReq | output | 1 | Interrupt request to the core |
| irqId | output | ID_W | Group number of the request |
| irqAck | input | 1 | Core takes the vector shown on irqId |
| rtiDone | input | 1 | Core returned from a handler |
| instrRetire | input | 1 | Core retired one instruction |

## Verification
The bench sweeps every pin of every group with its mask bit both on and off. It also sweeps all 64 combinations of pending flags and enables and checks the request and its group number against a lowest-index search it computes itself. It targets the edges where two things land together:
- A software clear at the same edge as a hardware set. A design with the wrong precedence would lose the event.
- A pin change during service. A design that clears the flag on return would drop the second interrupt.
- A retire pulse in the same cycle as the return. A design that counts it would issue the next vector with no instruction in between.
- A stray acknowledge with no request pending. A design that accepts it would lock the request low.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SERVICE = 2'd1,
    ST_GAP     = 2'd2
  } svcState_t;

  typedef struct packed {
    logic allowReq;
    logic takeVector;
  } ctlStrobe_t;

endpackage

// File: rtl/pcirq_datapath.sv
module pcirq_datapath
  import pcirq_pkg::*;
#(
  parameter int GROUPS = 3,
  parameter int PINS   = 8,
  localparam int ADDR_W = $clog2(GROUPS + 2),
  localparam int ID_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [GROUPS*PINS-1:0] pinsIn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWe,
  input  logic [PINS-1:0]        regWdata,
  output logic [PINS-1:0]        regRdata,
  input  ctlStrobe_t             strobes,
  output logic                   irqReqRaw,
  output logic                   irqReq,
  output logic [ID_W-1:0]        irqId
);

  localparam int NBITS = GROUPS * PINS;
  localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(GROUPS);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(GROUPS + 1);

  // two-flop synchroniser plus previous-sample register
  logic [NBITS-1:0] syncA, syncB, prevS, changeVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevS <= '0;
    end else begin
      syncA <= pinsIn;
      syncB <= syncA;
      prevS <= syncB;
    end
  end

  assign changeVec = syncB ^ prevS;

  logic [GROUPS-1:0][PINS-1:0] maskQ;
  logic [GROUPS-1:0] enQ, flagQ, flagNext, setVec, flagW1c, ackClr, pendVec;
  logic enWr, flagWr;

  assign enWr   = regWe && (regAddr == EN_ADDR);
  assign flagWr = regWe && (regAddr == FLAG_ADDR);

  // per-group mask registers and change reduction
  for (genvar g = 0; g < GROUPS; g++) begin : gen_group
    logic maskWr;
    assign maskWr = regWe && (regAddr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       maskQ[g] <= '0;
      else if (maskWr) maskQ[g] <= regWdata;
    end

    assign setVec[g] = |(changeVec[g*PINS +: PINS] & maskQ[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     enQ <= '0;
    else if (enWr) enQ <= regWdata[GROUPS-1:0];
  end

  // flag update: software clear and vector-take clear, hardware set wins
  assign flagW1c  = flagWr ? regWdata[GROUPS-1:0] : '0;
  assign ackClr   = strobes.takeVector ? (GROUPS'(1) << irqId) : '0;
  assign flagNext = (flagQ & ~flagW1c & ~ackClr) | setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext;
  end

  // fixed priority: lowest group index wins
  assign pendVec = flagQ & enQ;

  always_comb begin
    irqId = '0;
    for (int i = GROUPS - 1; i >= 0; i--) begin
      if (pendVec[i]) irqId = ID_W'(i);
    end
  end

  assign irqReqRaw = |pendVec;
  assign irqReq    = irqReqRaw && strobes.allowReq;

  // register read mux
  always_comb begin
    regRdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (regAddr == ADDR_W'(g)) regRdata = maskQ[g];
    end
    if (regAddr == EN_ADDR)   regRdata[GROUPS-1:0] = enQ;
    if (regAddr == FLAG_ADDR) regRdata[GROUPS-1:0] = flagQ;
  end

  // checks
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((flagQ & $past(setVec)) == $past(setVec)));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flagW1c != '0 && setVec == '0 && !strobes.takeVector) |=> ((flagQ & $past(flagW1c)) == '0));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeVector && !setVec[irqId]) |=> !flagQ[$past(irqId)]);

  assert_req_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (enQ[irqId] && flagQ[irqId]));

  assert_req_priority_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((pendVec & ((GROUPS'(1) << irqId) - GROUPS'(1))) == '0));

endmodule

// File: rtl/pcirq_control.sv
module pcirq_control
  import pcirq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqReqRaw,
  input  logic       irqAck,
  input  logic       rtiDone,
  input  logic       instrRetire,
  output ctlStrobe_t strobes
);

  svcState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (irqAck && irqReqRaw) stateNext = ST_SERVICE;
      ST_SERVICE: if (rtiDone)             stateNext = ST_GAP;
      ST_GAP:     if (instrRetire)         stateNext = ST_IDLE;
      default:                             stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobes.allowReq   = (state == ST_IDLE);
  assign strobes.takeVector = (state == ST_IDLE) && irqAck && irqReqRaw;

  // checks
  assert_take_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeVector |=> !strobes.allowReq);

  assert_rti_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SERVICE && rtiDone) |=> !strobes.allowReq);

  assert_gap_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && !instrRetire) |=> !strobes.allowReq);

  assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && irqAck && !irqReqRaw) |=> strobes.allowReq);

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcirq_pkg::*;
#(
  parameter int GROUPS = 3,
  parameter int PINS   = 8,
  localparam int ADDR_W = $clog2(GROUPS + 2),
  localparam int ID_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [GROUPS*PINS-1:0] pinsIn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWe,
  input  logic [PINS-1:0]        regWdata,
  output logic [PINS-1:0]        regRdata,
  output logic                   irqReq,
  output logic [ID_W-1:0]        irqId,
  input  logic                   irqAck,
  input  logic                   rtiDone,
  input  logic                   instrRetire
);

  ctlStrobe_t strobes;
  logic irqReqRaw;

  pcirq_datapath #(.GROUPS(GROUPS), .PINS(PINS)) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinsIn    (pinsIn),
    .regAddr   (regAddr),
    .regWe     (regWe),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .strobes   (strobes),
    .irqReqRaw (irqReqRaw),
    .irqReq    (irqReq),
    .irqId     (irqId)
  );

  pcirq_control control_i (
    .clk         (clk),
    .rstN        (rstN),
    .irqReqRaw   (irqReqRaw),
    .irqAck      (irqAck),
    .rtiDone     (rtiDone),
    .instrRetire (instrRetire),
    .strobes     (strobes)
  );

endmodule

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb_top;

  localparam int G  = 3;
  localparam int P  = 8;
  localparam int AW = $clog2(G + 2);
  localparam int IW = 2;
  localparam logic [AW-1:0] EN_A = AW'(G);
  localparam logic [AW-1:0] FL_A = AW'(G + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [G*P-1:0] pinsIn = '0;
  logic [AW-1:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [P-1:0] regWdata = '0;
  logic [P-1:0] regRdata;
  logic irqReq;
  logic [IW-1:0] irqId;
  logic irqAck = 1'b0, rtiDone = 1'b0, instrRetire = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_change_irq #(.GROUPS(G), .PINS(P)) dut_i (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq), .irqId(irqId),
    .irqAck(irqAck), .rtiDone(rtiDone), .instrRetire(instrRetire)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [P-1:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    step(1);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int v);
    regAddr = a;
    #1 v = int'(regRdata);
  endtask

  task automatic pulse(input int which);
    if (which == 0) irqAck = 1'b1;
    if (which == 1) rtiDone = 1'b1;
    if (which == 2) instrRetire = 1'b1;
    if (which == 3) begin rtiDone = 1'b1; instrRetire = 1'b1; end
    step(1);
    irqAck = 1'b0; rtiDone = 1'b0; instrRetire = 1'b0;
  endtask

  function automatic int lowest(input int v);
    for (int i = G - 1; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  initial begin
    int v;
    step(2);
    rstN = 1'b1;
    step(1);

    // R11: reset state
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), v);
      check(v == 0, "R11 reset register", v, 0);
    end
    check(irqReq == 1'b0, "R11 reset irqReq", int'(irqReq), 0);

    // R1: latency of synchroniser and detector
    wr(AW'(0), 8'h01);
    pinsIn[0] = ~pinsIn[0];
    step(2);
    rd(FL_A, v);
    check(v == 0, "R1 flag not yet set", v, 0);
    step(1);
    rd(FL_A, v);
    check(v == 1, "R1 flag set after sync", v, 1);

    // R1/R2/R3: sweep every pin, mask on and off, enables zero
    for (int g = 0; g < G; g++) begin
      for (int p = 0; p < P; p++) begin
        for (int m = 0; m < 2; m++) begin
          wr(AW'(g), (m == 1) ? P'(1 << p) : ~P'(1 << p));
          wr(FL_A, '1);
          pinsIn[g*P + p] = ~pinsIn[g*P + p];
          step(3);
          rd(FL_A, v);
          check(v == m * (1 << g), (m == 1) ? "R1 masked pin sets flag" : "R2 unmasked pin ignored",
                v, m * (1 << g));
          check(irqReq == 1'b0, "R3 disabled group no request", int'(irqReq), 0);
        end
      end
      wr(AW'(g), '0);
    end

    // R3: a second change on an already-set flag keeps it set
    wr(AW'(1), 8'h10);
    wr(FL_A, '1);
    pinsIn[P + 4] = ~pinsIn[P + 4];
    step(3);
    pinsIn[P + 4] = ~pinsIn[P + 4];
    step(3);
    rd(FL_A, v);
    check(v == 2, "R3 flag stays set on repeat change", v, 2);

    // R4: write-one-to-clear
    for (int g = 0; g < G; g++) wr(AW'(g), 8'h01);
    for (int g = 0; g < G; g++) pinsIn[g*P] = ~pinsIn[g*P];
    step(3);
    wr(FL_A, 8'h00);
    rd(FL_A, v);
    check(v == 7, "R4 writing zero keeps flags", v, 7);
    wr(FL_A, 8'h02);
    rd(FL_A, v);
    check(v == 5, "R4 writing one clears bit", v, 5);

    // R5: set and clear at the same edge
    pinsIn[0] = ~pinsIn[0];
    step(2);
    regAddr = FL_A; regWdata = 8'h01; regWe = 1'b1;
    step(1);
    regWe = 1'b0;
    rd(FL_A, v);
    check((v & 1) == 1, "R5 set beats clear", v & 1, 1);

    // R9/R3: all flag and enable combinations
    for (int f = 0; f < 8; f++) begin
      for (int e = 0; e < 8; e++) begin
        wr(EN_A, P'(e));
        wr(FL_A, '1);
        for (int g = 0; g < G; g++) if (f[g]) pinsIn[g*P] = ~pinsIn[g*P];
        step(3);
        check(irqReq == ((f & e) != 0), "R9 request presence", int'(irqReq), int'((f & e) != 0));
        if ((f & e) != 0)
          check(int'(irqId) == lowest(f & e), "R9 priority id", int'(irqId), lowest(f & e));
      end
    end

    // R12: stray acknowledge
    wr(EN_A, 8'h07);
    wr(FL_A, '1);
    step(1);
    pulse(0);
    pinsIn[2*P] = ~pinsIn[2*P];
    step(3);
    check(irqReq == 1'b1, "R12 stray ack ignored request", int'(irqReq), 1);
    check(int'(irqId) == 2, "R12 stray ack ignored id", int'(irqId), 2);

    // R6: ack clears only the served flag
    pinsIn[0] = ~pinsIn[0];
    step(3);
    check(int'(irqId) == 0, "R6 id before ack", int'(irqId), 0);
    pulse(0);
    rd(FL_A, v);
    check(v == 4, "R6 served flag cleared", v, 4);
    check(irqReq == 1'b0, "R8 request low in service", int'(irqReq), 0);

    // R7: change during service re-arms
    pinsIn[0] = ~pinsIn[0];
    step(3);
    rd(FL_A, v);
    check(v == 5, "R7 flag re-armed in service", v, 5);
    check(irqReq == 1'b0, "R8 still low in service", int'(irqReq), 0);

    // R8/R10: return with a same-cycle retire, then the gap retire
    pulse(3);
    rd(FL_A, v);
    check(v == 5, "R10 return clears no flag", v, 5);
    check(irqReq == 1'b0, "R8 same-cycle retire not counted", int'(irqReq), 0);
    step(2);
    check(irqReq == 1'b0, "R8 gap holds without retire", int'(irqReq), 0);
    pulse(2);
    check(irqReq == 1'b1, "R7 second interrupt after gap", int'(irqReq), 1);
    check(int'(irqId) == 0, "R7 second interrupt id", int'(irqId), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule